// File: doc/BRIEF.md
# FFT Output Bin Reorder Buffer

This block sits behind a radix-2 decimation-in-frequency FFT. The FFT delivers its frequency bins in bit-reversed index order, one complex bin per clock. A `in_valid` qualifier marks each bin, and a frame sync pulse comes one clock ahead of the first bin of each frame. The block captures each frame of N = 2^LOG2_N bins into one half of a ping-pong memory. While that frame is read out in the order the user picks, the next frame goes into the other half. A continuous stream therefore passes through with a latency of one frame.

Two configuration inputs set the read order. With reordering off, the bins leave in the order they arrived. With reordering on, the output is in natural order: DC first, then the positive bins, then the negative bins. With reordering and centering both on, the spectrum is centered: the negative bins first, then DC, then the positive bins. Centering without reordering is an illegal combination. The block does not honour it. It reads that frame in arrival order and raises a flag alongside every bin of the frame. The configuration is taken when a frame finishes being captured, and it holds for the whole readout of that frame.

The output carries its own sync pulse, which comes one clock before the first bin, and a valid signal that stays high for exactly N cycles per frame.

Top module: `bin_reorder_buf`

## Requirements
- R1: While `rst` is high, and in the cycle after any clock edge that sees `rst` high, `out_valid`, `out_sync` and `out_cfg_bad` are low.
- R2: Capture is disarmed after reset until the first `in_sync` pulse. Bins offered with `in_valid` before that pulse are never output.
- R3: With `cfg_reorder`=0 and `cfg_center`=0, bins leave in the same order in which they arrived.
- R4: The input bin at arrival position j (0-based, counted from the cycle after `in_sync`) is FFT bin bitrev(j) over LOG2_N bits. With `cfg_reorder`=1 and `cfg_center`=0, output position r carries bin r.
- R5: With `cfg_reorder`=1 and `cfg_center`=1, output position r carries bin r XOR N/2. The output order is bins N/2..N-1, then bins 0..N/2-1.
- R6: With `cfg_center`=1 and `cfg_reorder`=0, the frame is read in arrival order and `out_cfg_bad` is high with every output bin of that frame. In legal modes `out_cfg_bad` stays low.
- R7: `out_sync` is a one-cycle pulse in the cycle just before the first `out_valid` of a frame. `out_valid` is then high for exactly N consecutive cycles.
- R8: `out_sync` is high in the cycle right after the clock edge that captures the N-th bin of a frame. No output frame starts before N input bins have been taken since reset.
- R9: Frames sent back to back are all output completely and in order, with `out_valid` continuous. This holds when `in_sync` falls in the same cycle as the last bin of the previous frame.
- R10: An `in_sync` that arrives before a frame has N bins discards the partial frame. That frame produces no output.
- R11: The configuration is sampled on the edge that completes a frame. Changing it while that frame is being read out does not alter the frame's order.
- R12: Cycles with `in_valid` low inside a frame are skipped without affecting the captured order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_sync | input | 1 | Frame start pulse, one cycle before the first input bin |
| in_valid | input | 1 | Input bin qualifier |
| in_re | input | DATA_W | Real part of the input bin |
| in_im | input | DATA_W | Imaginary part of the input bin |
| cfg_reorder | input | 1 | 1: undo the bit-reversed order |
| cfg_center | input | 1 | 1: center the spectrum (legal only with cfg_reorder) |
| out_sync | output | 1 | Frame start pulse, one cycle before the first output bin |
| out_valid | output | 1 | Output bin qualifier |
| out_re | output | DATA_W | Real part of the output bin |
| out_im | output | DATA_W | Imaginary part of the output bin |
| out_cfg_bad | output | 1 | High with each bin of a frame captured under the illegal mode |

## Verification
Writing frame k+1 into one memory bank and reading frame k from the other happen in the same cycles. The frame-completion event can also land on the cycle that issues the last read of the previous frame. The bench provokes both by sending frames back to back in alternating modes, with `in_sync` on the last bin of each preceding frame. The scoreboard then requires every bin of every frame in order and an unbroken `out_valid`. The bench also changes the configuration during a readout, and requires that the frame keeps the order latched at its completion.

// File: rtl/bin_reorder_pkg.sv
package bin_reorder_pkg;

  // Read order selected for one output frame.
  typedef enum logic [1:0] {
    ORD_ARRIVAL  = 2'd0,
    ORD_NATURAL  = 2'd1,
    ORD_CENTERED = 2'd2
  } ord_mode_e;

  function automatic ord_mode_e decode_mode(input logic reorder, input logic center);
    if (reorder && center) return ORD_CENTERED;
    if (reorder)           return ORD_NATURAL;
    return ORD_ARRIVAL;
  endfunction

endpackage

// File: rtl/bin_wr_ctrl.sv
module bin_wr_ctrl #(
  parameter int LOG2_N = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_sync,
  input  logic              in_valid,
  output logic              wr_en,
  output logic [LOG2_N:0]   wr_addr,
  output logic              frame_done,
  output logic              done_bank
);
  localparam logic [LOG2_N-1:0] LAST_IDX = '1;

  logic              armed;
  logic              bank;
  logic [LOG2_N-1:0] idx;

  assign wr_en      = armed && in_valid;
  assign wr_addr    = {bank, idx};
  assign frame_done = wr_en && (idx == LAST_IDX);
  assign done_bank  = bank;

  always_ff @(posedge clk) begin
    if (rst) begin
      armed <= 1'b0;
      bank  <= 1'b0;
      idx   <= '0;
    end else begin
      if (in_sync) armed <= 1'b1;
      if (in_sync)
        idx <= '0;
      else if (wr_en)
        idx <= idx + 1'b1;
      if (frame_done) bank <= ~bank;
    end
  end

endmodule

// File: rtl/bin_rd_ctrl.sv
module bin_rd_ctrl
  import bin_reorder_pkg::*;
#(
  parameter int LOG2_N = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              start_bank,
  input  logic              cfg_reorder,
  input  logic              cfg_center,
  output logic              rd_en,
  output logic [LOG2_N:0]   rd_addr,
  output logic              o_sync,
  output logic              o_valid,
  output logic              o_bad
);
  localparam logic [LOG2_N-1:0] LAST_IDX = '1;
  localparam logic [LOG2_N-1:0] HALF     = {1'b1, {(LOG2_N-1){1'b0}}};

  logic              active;
  logic              bank;
  logic              bad_lat;
  logic [LOG2_N-1:0] cnt;
  ord_mode_e         mode;
  logic [LOG2_N-1:0] bin_sel;
  logic [LOG2_N-1:0] bin_rev;
  logic [LOG2_N-1:0] slot;

  // Bin wanted at this output position.
  always_comb begin
    bin_sel = cnt;
    if (mode == ORD_CENTERED) bin_sel = cnt ^ HALF;
  end

  // Storage slot of a bin is its bit-reversed index.
  for (genvar b = 0; b < LOG2_N; b++) begin : g_rev
    assign bin_rev[b] = bin_sel[LOG2_N-1-b];
  end

  always_comb begin
    slot = cnt;
    if (mode != ORD_ARRIVAL) slot = bin_rev;
  end

  assign rd_en   = active;
  assign rd_addr = {bank, slot};

  always_ff @(posedge clk) begin
    if (rst) begin
      active  <= 1'b0;
      bank    <= 1'b0;
      bad_lat <= 1'b0;
      cnt     <= '0;
      mode    <= ORD_ARRIVAL;
      o_sync  <= 1'b0;
      o_valid <= 1'b0;
      o_bad   <= 1'b0;
    end else begin
      if (start) begin
        active  <= 1'b1;
        cnt     <= '0;
        bank    <= start_bank;
        mode    <= decode_mode(cfg_reorder, cfg_center);
        bad_lat <= cfg_center && !cfg_reorder;
      end else if (active) begin
        cnt <= cnt + 1'b1;
        if (cnt == LAST_IDX) active <= 1'b0;
      end
      o_sync  <= start;
      o_valid <= active;
      o_bad   <= active && bad_lat;
    end
  end

endmodule

// File: rtl/pingpong_ram.sv
module pingpong_ram #(
  parameter int ADDR_W = 5,
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [WORD_W-1:0] wdata,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [WORD_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [WORD_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end

endmodule

// File: rtl/bin_reorder_buf.sv
module bin_reorder_buf #(
  parameter int LOG2_N = 4,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_sync,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_re,
  input  logic [DATA_W-1:0] in_im,
  input  logic              cfg_reorder,
  input  logic              cfg_center,
  output logic              out_sync,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_re,
  output logic [DATA_W-1:0] out_im,
  output logic              out_cfg_bad
);
  localparam int ADDR_W = LOG2_N + 1;
  localparam int WORD_W = 2 * DATA_W;

  logic              wr_en;
  logic [ADDR_W-1:0] wr_addr;
  logic              frame_done;
  logic              done_bank;
  logic              rd_en;
  logic [ADDR_W-1:0] rd_addr;
  logic [WORD_W-1:0] rd_word;

  bin_wr_ctrl #(.LOG2_N(LOG2_N)) u_wr (
    .clk        (clk),
    .rst        (rst),
    .in_sync    (in_sync),
    .in_valid   (in_valid),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .frame_done (frame_done),
    .done_bank  (done_bank)
  );

  pingpong_ram #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_ram (
    .clk   (clk),
    .we    (wr_en),
    .waddr (wr_addr),
    .wdata ({in_re, in_im}),
    .re    (rd_en),
    .raddr (rd_addr),
    .rdata (rd_word)
  );

  bin_rd_ctrl #(.LOG2_N(LOG2_N)) u_rd (
    .clk         (clk),
    .rst         (rst),
    .start       (frame_done),
    .start_bank  (done_bank),
    .cfg_reorder (cfg_reorder),
    .cfg_center  (cfg_center),
    .rd_en       (rd_en),
    .rd_addr     (rd_addr),
    .o_sync      (out_sync),
    .o_valid     (out_valid),
    .o_bad       (out_cfg_bad)
  );

  assign out_re = rd_word[WORD_W-1:DATA_W];
  assign out_im = rd_word[DATA_W-1:0];

endmodule

// File: rtl/bin_reorder_buf_chk.sv
module bin_reorder_buf_chk #(
  parameter int LOG2_N = 4
) (
  input logic clk,
  input logic rst,
  input logic in_valid,
  input logic out_sync,
  input logic out_valid,
  input logic out_cfg_bad
);
  localparam logic [LOG2_N:0] NFULL = {1'b1, {LOG2_N{1'b0}}};

  logic [LOG2_N:0] vcnt;
  logic [LOG2_N:0] in_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      vcnt   <= '0;
      in_cnt <= '0;
    end else begin
      if (out_sync)       vcnt <= '0;
      else if (out_valid) vcnt <= vcnt + 1'b1;
      if (in_valid && in_cnt != NFULL) in_cnt <= in_cnt + 1'b1;
    end
  end

  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> (!out_valid && !out_sync && !out_cfg_bad)); // R1

  AST_SYNC_LEADS_VALID: assert property (@(posedge clk) disable iff (rst)
    out_sync |=> out_valid); // R7

  AST_VALID_HAS_SYNC: assert property (@(posedge clk) disable iff (rst)
    $rose(out_valid) |-> $past(out_sync)); // R7

  AST_FRAME_LENGTH: assert property (@(posedge clk) disable iff (rst)
    $fell(out_valid) |-> (vcnt == NFULL)); // R7

  AST_FRAME_NOT_LONG: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_sync) |-> (vcnt < NFULL)); // R7

  AST_NO_EARLY_FRAME: assert property (@(posedge clk) disable iff (rst)
    out_sync |-> (in_cnt == NFULL)); // R8

  AST_BAD_WITH_DATA: assert property (@(posedge clk) disable iff (rst)
    out_cfg_bad |-> out_valid); // R6

endmodule

bind bin_reorder_buf bin_reorder_buf_chk #(.LOG2_N(LOG2_N)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .in_valid    (in_valid),
  .out_sync    (out_sync),
  .out_valid   (out_valid),
  .out_cfg_bad (out_cfg_bad)
);

// File: tb/tb_bin_reorder_buf.sv
module tb_bin_reorder_buf;
  localparam int LOG2_N = 4;
  localparam int N      = 1 << LOG2_N;
  localparam int DATA_W = 16;

  logic              clk = 1'b0;
  logic              rst;
  logic              in_sync, in_valid, cfg_reorder, cfg_center;
  logic [DATA_W-1:0] in_re, in_im;
  logic              out_sync, out_valid, out_cfg_bad;
  logic [DATA_W-1:0] out_re, out_im;

  int checks = 0;
  int fails  = 0;
  int out_seen = 0;
  bit done = 0;
  string cur_req = "R3";
  logic [2*DATA_W:0] expq [$];

  always #10 clk = ~clk;

  bin_reorder_buf #(.LOG2_N(LOG2_N), .DATA_W(DATA_W)) dut (
    .clk(clk), .rst(rst), .in_sync(in_sync), .in_valid(in_valid),
    .in_re(in_re), .in_im(in_im), .cfg_reorder(cfg_reorder), .cfg_center(cfg_center),
    .out_sync(out_sync), .out_valid(out_valid), .out_re(out_re), .out_im(out_im),
    .out_cfg_bad(out_cfg_bad)
  );

  function automatic int bitrev(input int v);
    int r = 0;
    for (int b = 0; b < LOG2_N; b++) if (v[b]) r |= 1 << (LOG2_N-1-b);
    return r;
  endfunction

  function automatic logic [DATA_W-1:0] re_of(input int tag, input int bin);
    return DATA_W'((tag << LOG2_N) | bin);
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  // Push the expected output frame (R3 arrival, R4 natural, R5 centered, R6 illegal).
  task automatic push_expected(input int tag, input bit ro, input bit ce);
    for (int r = 0; r < N; r++) begin
      int bin;
      bit bad;
      bad = ce && !ro;
      if (ro && ce)  bin = r ^ (N/2);
      else if (ro)   bin = r;
      else           bin = bitrev(r);
      expq.push_back({bad, re_of(tag, bin), re_of(tag, bin) ^ 16'h5A3C});
    end
  endtask

  task automatic drive_frame(input int tag, input bit ro, input bit ce,
                             input bit lead_sync, input bit sync_last,
                             input bit gap, input bit idle_after);
    if (lead_sync) begin
      @(posedge clk); #1;
      in_sync = 1; in_valid = 0;
    end
    for (int j = 0; j < N; j++) begin
      if (gap && j == N/2) begin
        for (int g = 0; g < 3; g++) begin
          @(posedge clk); #1;
          in_sync = 0; in_valid = 0;
        end
      end
      @(posedge clk); #1;
      cfg_reorder = ro; cfg_center = ce;
      in_sync  = sync_last && (j == N-1);
      in_valid = 1;
      in_re    = re_of(tag, bitrev(j));
      in_im    = re_of(tag, bitrev(j)) ^ 16'h5A3C;
      if (j == N-1) push_expected(tag, ro, ce);
    end
    if (idle_after) begin
      @(posedge clk); #1;
      in_sync = 0; in_valid = 0;
      check("R8 out_sync after capture", 64'(out_sync), 64'd1);
    end
  endtask

  // Monitor / scoreboard.
  logic prev_sync = 0, prev_valid = 0;
  always @(negedge clk) begin
    if (!rst && out_valid) begin
      out_seen++;
      if (!prev_valid)
        check("R7 sync precedes valid", 64'(prev_sync), 64'd1);
      if (expq.size() == 0) begin
        checks++; fails++;
        $display("FAIL %s actual=unexpected_output expected=none", cur_req);
      end else begin
        logic [2*DATA_W:0] e;
        e = expq.pop_front();
        check(cur_req, 64'({out_cfg_bad, out_re, out_im}), 64'(e));
      end
    end
    prev_sync  = out_sync;
    prev_valid = out_valid;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    rst = 1; in_sync = 0; in_valid = 0; in_re = '0; in_im = '0;
    cfg_reorder = 1; cfg_center = 0;
    repeat (3) @(posedge clk);
    #1;
    check("R1 out_valid", 64'(out_valid), 64'd0);
    check("R1 out_sync", 64'(out_sync), 64'd0);
    check("R1 out_cfg_bad", 64'(out_cfg_bad), 64'd0);
    rst = 0;

    // R2: data before any sync is ignored.
    cur_req = "R2";
    for (int k = 0; k < N + 4; k++) begin
      @(posedge clk); #1;
      in_valid = 1; in_re = 16'hDEAD; in_im = 16'hBEEF;
    end
    @(posedge clk); #1; in_valid = 0;
    repeat (N + 4) @(posedge clk);
    #1;
    check("R2 no output before sync", 64'(out_seen), 64'd0);

    // R4 natural order, with an input gap (R12).
    cur_req = "R4/R12";
    drive_frame(1, 1, 0, 1, 0, 1, 1);
    repeat (N + 4) @(posedge clk);

    cur_req = "R3";
    drive_frame(2, 0, 0, 1, 0, 0, 1);
    repeat (N + 4) @(posedge clk);

    cur_req = "R5";
    drive_frame(3, 1, 1, 1, 0, 0, 1);
    repeat (N + 4) @(posedge clk);

    cur_req = "R6";
    drive_frame(4, 0, 1, 1, 0, 0, 1);
    repeat (N + 4) @(posedge clk);

    // R9: back to back, sync on the last bin of each preceding frame.
    cur_req = "R9";
    begin
      int seen0;
      seen0 = out_seen;
      drive_frame(5, 1, 0, 1, 1, 0, 0);
      drive_frame(6, 1, 1, 0, 1, 0, 0);
      drive_frame(7, 0, 0, 0, 0, 0, 1);
      repeat (N + 4) @(posedge clk);
      #1;
      check("R9 bins from three frames", 64'(out_seen - seen0), 64'(3*N));
    end

    // R10: partial frame then a new sync.
    cur_req = "R10";
    @(posedge clk); #1; in_sync = 1; in_valid = 0;
    for (int k = 0; k < 5; k++) begin
      @(posedge clk); #1;
      in_sync = 0; in_valid = 1; in_re = 16'hBAD0; in_im = 16'hBAD1;
    end
    drive_frame(8, 1, 0, 1, 0, 0, 1);
    repeat (N + 4) @(posedge clk);

    // R11: configuration changed during readout.
    cur_req = "R11";
    drive_frame(9, 1, 1, 1, 0, 0, 1);
    cfg_reorder = 0; cfg_center = 1;
    repeat (N + 4) @(posedge clk);
    #1;
    check("R11 out_cfg_bad low after legal frame", 64'(out_cfg_bad), 64'd0);

    check("scoreboard drained", 64'(expq.size()), 64'd0);
    finish_run();
  end

endmodule